// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer with Supply-Fail Override

This block supervises a processor by watching one input that the software keeps changing. The block counts clock cycles from the last change it saw. If no change arrives within a parameterised number of cycles, the active-low fault output drops.

The counter restarts on a rising change and on a falling change of that input. It also clears whenever the system reset is asserted, so timing only begins after reset is released. A power-good input pulls the output low whenever it is deasserted. This happens at any time, whether or not the count has run out.

An enable input stands in for the hardware disable mode. While it is low, no timeout can occur and the output simply mirrors power-good. This turns the output into a low-supply indicator. The watchdog input may be fully asynchronous. Power-good and enable are expected to be synchronous to the clock.

Top module: `wdt_pf_guard`

## Requirements
- R1: While rst_ni is low, wdo_no is high if pgood_i is high; leaving reset, the counter starts at zero with no fault pending.
- R2: With en_i high and no recognised transition, wdo_no falls exactly TIMEOUT_CYC clock edges after the last clearing edge and stays low until cleared.
- R3: A 0-to-1 change on wdi_i clears the counter.
- R4: A 1-to-0 change on wdi_i clears the counter.
- R5: Asserting rst_ni mid-count discards the elapsed count; after release the full TIMEOUT_CYC period is needed before a fault.
- R6: pgood_i low drives wdo_no low in the same cycle, without waiting for a clock edge, regardless of the timer.
- R7: A power-good dip neither clears nor pauses the counter; once power-good returns, the fault appears at the time it would have appeared anyway.
- R8: While en_i is low, the counter is held at zero and wdo_no equals pgood_i; after en_i rises, a fault needs TIMEOUT_CYC more edges.
- R9: After a fault, the next wdi_i transition, or a reset assertion, returns wdo_no high and restarts the count from zero.
- R10: A change on wdi_i passes through a two-flop synchroniser. It takes effect at the third rising clock edge after the change. If that edge is also the expiry edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the timer |
| wdi_i | input | 1 | Watchdog input toggled by software, asynchronous |
| pgood_i | input | 1 | Power-good, high when the supply is above threshold |
| en_i | input | 1 | Watchdog enable; low disables timeout detection |
| wdo_no | output | 1 | Active-low watchdog/power-fail flag |

## Verification
Several properties are checked on every cycle:
- the supply override forces the output low;
- a disabled timer makes the output mirror power-good;
- the count never exceeds the limit, and any fall of the output under good power happens only from the final count value;
- a raised fault latches until a clear;
- the counter leaves reset empty.

The bench scenarios are needed for the end-to-end timing, which no single-cycle property captures. This covers the exact expiry edge measured from a wdi_i change through the synchroniser, toggling one cycle ahead of the limit, and a power-good dip in mid-count that leaves the expiry time unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // 1.6 s at a 50 MHz clock
  localparam int unsigned DEF_TIMEOUT_CYC = 80_000_000;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/wdt_in_sync.sv
module wdt_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[gi] <= 1'b0;
        else         sh_q[gi] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[gi] <= 1'b0;
        else         sh_q[gi] <= sh_q[gi-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sh_q[STAGES-1];
  end

  // either polarity of change counts as activity
  assign edge_o = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned TIMEOUT_CYC = 16,
  localparam int unsigned CW = wdt_pkg::cnt_width(TIMEOUT_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic          expired_o
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (clr_i || !en_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!exp_q) begin
      if (cnt_q == LAST) exp_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = exp_q;
endmodule

// File: rtl/wdt_out_stage.sv
module wdt_out_stage (
  input  logic expired_i,
  input  logic pgood_i,
  output logic wdo_no
);
  // supply failure overrides the timer without waiting for a clock
  assign wdo_no = pgood_i & ~expired_i;
endmodule

// File: rtl/wdt_pf_guard.sv
module wdt_pf_guard #(
  parameter int unsigned TIMEOUT_CYC = wdt_pkg::DEF_TIMEOUT_CYC,
  parameter int unsigned SYNC_STAGES = wdt_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_i,
  input  logic pgood_i,
  input  logic en_i,
  output logic wdo_no
);
  localparam int unsigned CW = wdt_pkg::cnt_width(TIMEOUT_CYC);

  logic          edge_w;
  logic [CW-1:0] cnt_w;
  logic          expired_w;

  wdt_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wdi_i),
    .edge_o(edge_w)
  );

  wdt_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (edge_w),
    .en_i     (en_i),
    .cnt_o    (cnt_w),
    .expired_o(expired_w)
  );

  wdt_out_stage u_out (
    .expired_i(expired_w),
    .pgood_i  (pgood_i),
    .wdo_no   (wdo_no)
  );
endmodule

// File: rtl/wdt_pf_guard_chk.sv
module wdt_pf_guard_chk #(
  parameter int unsigned TIMEOUT_CYC = 16,
  localparam int unsigned CW = wdt_pkg::cnt_width(TIMEOUT_CYC)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pgood_i,
  input logic          en_i,
  input logic          wdo_no,
  input logic          edge_w,
  input logic [CW-1:0] cnt_w,
  input logic          expired_w
);
  a_r6_pfail_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgood_i |-> !wdo_no);

  a_r8_disabled_mirrors_pgood: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!en_i) && !en_i) |-> (wdo_no == pgood_i));

  a_r2_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_w) < int'(TIMEOUT_CYC));

  a_r2_fall_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(wdo_no) && pgood_i && $past(pgood_i)) |->
      (int'($past(cnt_w)) == int'(TIMEOUT_CYC) - 1));

  a_r2_fault_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_w && !edge_w && en_i) |=> expired_w);

  a_r5_leave_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cnt_w == '0 && !expired_w));
endmodule

bind wdt_pf_guard wdt_pf_guard_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pgood_i  (pgood_i),
  .en_i     (en_i),
  .wdo_no   (wdo_no),
  .edge_w   (edge_w),
  .cnt_w    (cnt_w),
  .expired_w(expired_w)
);

// File: tb/tb_wdt_pf_guard.sv
module tb_wdt_pf_guard;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdi = 1'b0;
  logic pg = 1'b1;
  logic en = 1'b1;
  logic wdo_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  wdt_pf_guard #(.TIMEOUT_CYC(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wdi_i(wdi),
    .pgood_i(pg), .en_i(en), .wdo_no(wdo_n)
  );

  always #10 clk = ~clk;

  // behavioural reference: delay line of input samples plus an idle counter
  bit m_line[$];
  bit m_seen;
  int m_idle;
  bit m_fault;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = '{1'b0, 1'b0};
      m_seen = 1'b0;
      m_idle = 0;
      m_fault = 1'b0;
    end else begin
      bit oldest;
      bit act;
      oldest = m_line[1];
      act = (oldest != m_seen);
      m_seen = oldest;
      m_line.push_front(wdi);
      void'(m_line.pop_back());
      if (act || !en) begin
        m_idle = 0;
        m_fault = 1'b0;
      end else if (!m_fault) begin
        if (m_idle == TO - 1) m_fault = 1'b1;
        else m_idle++;
      end
    end
  end

  task automatic check(bit act_v, bit exp_v, string req);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: wdo_no=%b expected %b at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edges
  always @(negedge clk) begin
    #5;
    if (!done) check(wdo_n, pg & ~m_fault, "model R2 R6 R8");
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tog();
    wdi = ~wdi;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(3);
    check(wdo_n, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    tick(1);
    check(wdo_n, 1'b1, "R1 after release");

    // R2 missed toggle, R3 rising change, R10 latency
    tog();
    tick(2 + TO);
    check(wdo_n, 1'b1, "R2 one edge before limit");
    tick(1);
    check(wdo_n, 1'b0, "R2 R3 R10 fault at limit");
    tick(4);
    check(wdo_n, 1'b0, "R2 fault held");

    // R9 recovery, R4 falling change
    tog();
    tick(2);
    check(wdo_n, 1'b0, "R9 before sync delay");
    tick(1);
    check(wdo_n, 1'b1, "R4 R9 R10 recovered");

    // toggling one cycle before the limit never faults
    for (int k = 0; k < 6; k++) begin
      tick(TO - 1);
      check(wdo_n, 1'b1, "R3 R4 toggle before limit");
      tog();
    end
    // toggle exactly on the limit: clear wins
    tick(TO);
    check(wdo_n, 1'b1, "R10 clear vs expiry");
    tog();
    tick(3);
    check(wdo_n, 1'b1, "R10 clear vs expiry after");

    // R6 R7 power-fail mid-count
    tog();
    tick(5);
    pg = 1'b0;
    #1 check(wdo_n, 1'b0, "R6 immediate override");
    tick(4);
    check(wdo_n, 1'b0, "R6 override held");
    pg = 1'b1;
    #1 check(wdo_n, 1'b1, "R7 restored");
    tick(2 + TO - 9);
    check(wdo_n, 1'b1, "R7 before original limit");
    tick(1);
    check(wdo_n, 1'b0, "R7 fault at original limit");

    // R8 disable
    en = 1'b0;
    tick(1);
    check(wdo_n, 1'b1, "R8 disable clears fault");
    tick(3 * TO);
    check(wdo_n, 1'b1, "R8 no timeout while disabled");
    pg = 1'b0;
    #1 check(wdo_n, 1'b0, "R8 mirrors pgood low");
    tick(2);
    pg = 1'b1;
    #1 check(wdo_n, 1'b1, "R8 mirrors pgood high");
    en = 1'b1;
    tick(TO - 1);
    check(wdo_n, 1'b1, "R8 re-enable before limit");
    tick(1);
    check(wdo_n, 1'b0, "R8 re-enable fault at limit");

    // R9 reset clears a pending fault; R5 reset mid-count
    if (wdi) tog();
    tick(1);
    rst_n = 1'b0;
    #1 check(wdo_n, 1'b1, "R9 reset clears fault");
    tick(2);
    rst_n = 1'b1;
    tick(10);
    rst_n = 1'b0;
    #1 check(wdo_n, 1'b1, "R1 R5 in reset");
    tick(2);
    rst_n = 1'b1;
    tick(TO - 1);
    check(wdo_n, 1'b1, "R5 full period after release");
    tick(1);
    check(wdo_n, 1'b0, "R5 fault after full period");

    tick(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule